// File: doc/BRIEF.md
# Binary32 Condition-Flag Comparator

This block orders two single-precision operands, a first operand D and a second operand M, and reports the outcome as a four-bit condition code. It also flags an invalid operation. Each result holds exactly one of four patterns: equal, less, greater or unordered. The ordering works on the packed 32-bit words as unsigned integers, with a sign correction, so no field is ever unpacked or normalised. A per-transaction mode bit chooses between a quiet compare and a signaling compare. A second bit replaces M with positive zero, which gives the compare-against-zero forms.

Operands enter on a valid/ready stream and results leave on another. A beat is accepted on a rising edge where `in_valid` and `in_ready` are both high. When the `REG_OUT` parameter is 1 (the default), the result appears one cycle later and stays on the output until `out_ready` is high. `in_ready` is low only while a result is held and `out_ready` is low. This is back-pressure without a bubble: a new operand pair is taken in the same cycle the held result leaves. When `REG_OUT` is 0 the path is combinational, with `out_valid = in_valid` and `in_ready = out_ready`.

Top module: `fp32_flag_compare`

## Requirements
- R1: An operand whose exponent field (bits 30:23) is all ones and whose fraction (bits 22:0) is nonzero is a NaN. If either operand is a NaN, the result is unordered, with flags 4'b0011 (C and V set). The flag bit order is N=bit 3, Z=bit 2, C=bit 1, V=bit 0.
- R2: Each NaN operand is checked for invalid on its own terms. In signaling mode (`in_signal`=1) every NaN raises `out_invalid`. In quiet mode only a NaN with fraction bit 22 clear raises it. A quiet NaN in quiet mode leaves `out_invalid` at 0.
- R3: With no NaN, the result is equal (4'b0110, Z and C) when the two words are identical or when both are zeros of any sign.
- R4: With no NaN, no equality and differing sign bits, a negative D gives less (4'b1000, N) and a positive D gives greater (4'b0010, C).
- R5: With no NaN, no equality and equal signs, the result comes from an unsigned compare of the raw words. D below M gives less and D above M gives greater when both are positive. The sense is inverted when both are negative.
- R6: When `in_vs_zero`=1, M is taken as +0 (32'h0000_0000), and the value on `in_m` has no effect on the flags or on `out_invalid`.
- R7: Every result is exactly one of 4'b0110, 4'b1000, 4'b0010 or 4'b0011. `out_invalid` is 0 whenever no operand is a NaN. Infinities are ordered by the same raw-word rule as finite values.
- R8: With `REG_OUT`=1, `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_nzcv` and `out_invalid` hold their values.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair valid |
| in_ready | output | 1 | Block can accept an operand pair |
| in_d | input | 32 | First operand D, binary32 |
| in_m | input | 32 | Second operand M, binary32 |
| in_signal | input | 1 | 1 = signaling compare, 0 = quiet compare |
| in_vs_zero | input | 1 | 1 = compare D against +0 instead of M |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_nzcv | output | 4 | Condition flags {N,Z,C,V} |
| out_invalid | output | 1 | Invalid-operation flag |

## Verification
The assertions assume that the operand and mode inputs carry known values whenever `in_valid` is high. They also assume that the consumer obeys the stream rules, so a result is treated as consumed only on an edge where `out_ready` is high. The stimulus changes every input only on the falling clock edge and holds `out_ready` high except in the back-pressure scenario, so every captured beat is well defined. The directed operands are hand-picked encodings of signed zeros, ones, twos, infinities, a negative subnormal and both NaN kinds. Their expected flags are written down from the requirements rather than computed by a model.

// File: rtl/fp32_cmp_pkg.sv
package fp32_cmp_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned EXP_W  = 8;
  localparam int unsigned FRAC_W = WORD_W - EXP_W - 1;
  localparam int unsigned FLAG_W = 4;

  // {N,Z,C,V}
  localparam logic [FLAG_W-1:0] FLAGS_EQ = 4'b0110;
  localparam logic [FLAG_W-1:0] FLAGS_LT = 4'b1000;
  localparam logic [FLAG_W-1:0] FLAGS_GT = 4'b0010;
  localparam logic [FLAG_W-1:0] FLAGS_UN = 4'b0011;

  typedef struct packed {
    logic [FLAG_W-1:0] nzcv;
    logic              invalid;
  } cmp_result_t;
endpackage

// File: rtl/fp32_nan_probe.sv
module fp32_nan_probe #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] word,
  input  logic                  signal_mode,
  output logic                  is_nan,
  output logic                  raise_inv
);
  localparam int unsigned QUIET_BIT = FRAC_W - 1;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign exp_f  = word[EXP_W+FRAC_W-1:FRAC_W];
  assign frac_f = word[FRAC_W-1:0];

  always_comb begin
    is_nan    = (&exp_f) && (|frac_f);
    // signaling NaN has the top fraction bit clear
    raise_inv = is_nan && (signal_mode || !frac_f[QUIET_BIT]);
  end
endmodule

// File: rtl/fp32_word_order.sv
module fp32_word_order #(
  parameter int unsigned WORD_W = 32
) (
  input  logic [WORD_W-1:0] d_word,
  input  logic [WORD_W-1:0] m_word,
  output logic              eq,
  output logic              lt,
  output logic              gt
);
  localparam int unsigned SIGN = WORD_W - 1;

  logic d_neg, m_neg, raw_lt, raw_gt, both_zero;

  always_comb begin
    d_neg     = d_word[SIGN];
    m_neg     = m_word[SIGN];
    raw_lt    = d_word < m_word;
    raw_gt    = d_word > m_word;
    both_zero = ((d_word[SIGN-1:0] | m_word[SIGN-1:0]) == '0);
    eq = (d_word == m_word) || both_zero;
    lt = 1'b0;
    gt = 1'b0;
    if (!eq) begin
      if (d_neg != m_neg) begin
        lt = d_neg;
        gt = !d_neg;
      end else begin
        lt = d_neg ? raw_gt : raw_lt;
        gt = d_neg ? raw_lt : raw_gt;
      end
    end
  end

  always_comb begin
    if (!$isunknown({d_word, m_word}))
      assert_order_exclusive_R7: assert ($countones({eq, lt, gt}) == 1)
        else $error("order outputs not one-hot");
  end
endmodule

// File: rtl/fp32_stream_stage.sv
module fp32_stream_stage #(
  parameter int unsigned DATA_W  = 5,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [DATA_W-1:0] dn_data
);
  generate
    if (REG_OUT) begin : g_reg
      logic              valid_q;
      logic [DATA_W-1:0] data_q;

      assign up_ready = !valid_q || dn_ready;
      assign dn_valid = valid_q;
      assign dn_data  = data_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          valid_q <= 1'b0;
          data_q  <= '0;
        end else if (up_ready) begin
          valid_q <= up_valid;
          if (up_valid) data_q <= up_data;
        end
      end

      assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)))
        else $error("result changed under back-pressure");
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign up_ready = dn_ready;
      assign dn_valid = up_valid;
      assign dn_data  = up_data;
    end
  endgenerate
endmodule

// File: rtl/fp32_flag_compare.sv
module fp32_flag_compare
  import fp32_cmp_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_d,
  input  logic [WORD_W-1:0] in_m,
  input  logic              in_signal,
  input  logic              in_vs_zero,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [FLAG_W-1:0] out_nzcv,
  output logic              out_invalid
);
  localparam int unsigned RES_W = $bits(cmp_result_t);

  logic [WORD_W-1:0] m_eff;
  logic d_nan, m_nan, d_inv, m_inv;
  logic ord_eq, ord_lt, ord_gt;
  cmp_result_t res_c, res_q;

  assign m_eff = in_vs_zero ? '0 : in_m;

  fp32_nan_probe #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_probe_d (
    .word(in_d), .signal_mode(in_signal), .is_nan(d_nan), .raise_inv(d_inv));

  fp32_nan_probe #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_probe_m (
    .word(m_eff), .signal_mode(in_signal), .is_nan(m_nan), .raise_inv(m_inv));

  fp32_word_order #(.WORD_W(WORD_W)) u_order (
    .d_word(in_d), .m_word(m_eff), .eq(ord_eq), .lt(ord_lt), .gt(ord_gt));

  always_comb begin
    res_c.invalid = d_inv || m_inv;
    if (d_nan || m_nan) res_c.nzcv = FLAGS_UN;
    else if (ord_eq)    res_c.nzcv = FLAGS_EQ;
    else if (ord_lt)    res_c.nzcv = FLAGS_LT;
    else                res_c.nzcv = FLAGS_GT;
  end

  fp32_stream_stage #(.DATA_W(RES_W), .REG_OUT(REG_OUT)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .up_valid(in_valid), .up_ready(in_ready), .up_data(res_c),
    .dn_valid(out_valid), .dn_ready(out_ready), .dn_data(res_q));

  assign out_nzcv    = res_q.nzcv;
  assign out_invalid = res_q.invalid;

  assert_invalid_unordered_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |-> (out_nzcv == FLAGS_UN))
    else $error("invalid raised on an ordered result");

  assert_single_pattern_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_nzcv == FLAGS_EQ || out_nzcv == FLAGS_LT ||
                   out_nzcv == FLAGS_GT || out_nzcv == FLAGS_UN))
    else $error("illegal flag pattern");

  assert_ready_rule_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready)
    else $error("accepting while result is stalled");

  assert_zero_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_vs_zero && !d_nan && (in_d[WORD_W-2:0] == '0)) |->
      (res_c.nzcv == FLAGS_EQ && !res_c.invalid))
    else $error("signed zero against +0 not equal");
endmodule

// File: tb/fp32_flag_compare_bench.sv
`timescale 1ns/100ps
module fp32_flag_compare_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [31:0] in_d = '0;
  logic [31:0] in_m = '0;
  logic in_signal = 1'b0;
  logic in_vs_zero = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [3:0] out_nzcv;
  logic out_invalid;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  localparam logic [3:0] EQ = 4'b0110, LT = 4'b1000, GT = 4'b0010, UN = 4'b0011;

  always #2.5 clk = ~clk;

  fp32_flag_compare u_fp32_flag_compare (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_d(in_d), .in_m(in_m), .in_signal(in_signal), .in_vs_zero(in_vs_zero),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_nzcv(out_nzcv), .out_invalid(out_invalid));

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] d, input logic [31:0] m, input bit sig, input bit z,
                     input logic [3:0] ef, input bit ei, input string req);
    @(negedge clk);
    in_d = d; in_m = m; in_signal = sig; in_vs_zero = z; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_nzcv == ef && out_invalid == ei, req,
          {out_valid, 2'b0, out_invalid, out_nzcv}, {1'b1, 2'b0, ei, ef});
  endtask

  task automatic test_reset;
    check(out_valid == 1'b0, "R9 out_valid", {7'b0, out_valid}, 8'h00);
    check(in_ready == 1'b1, "R9 in_ready", {7'b0, in_ready}, 8'h01);
  endtask

  task automatic test_equal;
    run(32'h3F80_0000, 32'h3F80_0000, 1'b0, 1'b0, EQ, 1'b0, "R3 identical");
    run(32'h0000_0000, 32'h8000_0000, 1'b1, 1'b0, EQ, 1'b0, "R3 +0 vs -0");
  endtask

  task automatic test_signs;
    run(32'hBF80_0000, 32'h4000_0000, 1'b0, 1'b0, LT, 1'b0, "R4 neg D");
    run(32'h4000_0000, 32'hBF80_0000, 1'b0, 1'b0, GT, 1'b0, "R4 pos D");
  endtask

  task automatic test_same_sign;
    run(32'h3F80_0000, 32'h4000_0000, 1'b0, 1'b0, LT, 1'b0, "R5 pos lt");
    run(32'hBF80_0000, 32'hC000_0000, 1'b0, 1'b0, GT, 1'b0, "R5 neg inverted gt");
    run(32'hC000_0000, 32'hBF80_0000, 1'b0, 1'b0, LT, 1'b0, "R5 neg inverted lt");
    run(32'h7F80_0000, 32'h4000_0000, 1'b1, 1'b0, GT, 1'b0, "R7 +inf ordered");
    run(32'hFF80_0000, 32'hBF80_0000, 1'b1, 1'b0, LT, 1'b0, "R7 -inf ordered");
  endtask

  task automatic test_nan;
    run(32'h7FC0_0000, 32'h3F80_0000, 1'b0, 1'b0, UN, 1'b0, "R1 qNaN quiet");
    run(32'h7FC0_0000, 32'h3F80_0000, 1'b1, 1'b0, UN, 1'b1, "R2 qNaN signaling");
    run(32'h7F80_0001, 32'h3F80_0000, 1'b0, 1'b0, UN, 1'b1, "R2 sNaN D quiet");
    run(32'h3F80_0000, 32'h7F80_0001, 1'b0, 1'b0, UN, 1'b1, "R2 sNaN M quiet");
    run(32'hFFC0_0001, 32'h7FC0_0000, 1'b0, 1'b0, UN, 1'b0, "R1 two qNaN quiet");
  endtask

  task automatic test_vs_zero;
    run(32'h3F80_0000, 32'h7F80_0001, 1'b0, 1'b1, GT, 1'b0, "R6 M ignored");
    run(32'h8000_0000, 32'hC000_0000, 1'b0, 1'b1, EQ, 1'b0, "R6 -0 vs zero");
    run(32'h8000_0001, 32'h7FC0_0000, 1'b1, 1'b1, LT, 1'b0, "R6 neg subnormal");
  endtask

  task automatic test_backpressure;
    logic [3:0] held;
    @(negedge clk);
    out_ready = 1'b0;
    in_d = 32'h4000_0000; in_m = 32'h3F80_0000; in_signal = 1'b0; in_vs_zero = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    in_d = 32'hBF80_0000;
    held = out_nzcv;
    check(out_valid && out_nzcv == GT, "R8 first result", {3'b0, out_valid, out_nzcv}, {4'b0001, GT});
    check(in_ready == 1'b0, "R8 ready low", {7'b0, in_ready}, 8'h00);
    @(negedge clk);
    check(out_valid && out_nzcv == held, "R8 held", {3'b0, out_valid, out_nzcv}, {4'b0001, held});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_nzcv == LT, "R8 queued beat", {3'b0, out_valid, out_nzcv}, {4'b0001, LT});
    @(negedge clk);
    check(out_valid == 1'b0, "R8 drained", {7'b0, out_valid}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_equal();
    test_signs();
    test_same_sign();
    test_nan();
    test_vs_zero();
    test_backpressure();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule